// File: doc/BRIEF.md
# Buffered I2C Transaction Engine

This block is an I2C master that carries out one complete bus transaction without help once launched: an optional START, one address byte, a counted burst of up to fifteen payload bytes in either direction, and an optional STOP. Software stages the address byte and any payload through a byte-wide load port. It then presents the byte count, clock prescale, time limit, direction, condition enables and pin-pair choice, and pulses GO. While the transaction runs, GO reads back as busy. At the end, DONE, NACK or HALT tells software how it went. Bytes received from the target are popped from the same buffer through a read port, in the order they arrived.

The engine has a single-requester ownership handshake. A request is granted only while no other agent owns the bus, and GO is ignored unless the grant is held and the engine enable is set. A count of zero gives a probe: only the address byte is sent, which shows whether a target acknowledges. A time-limit watchdog measured in prescaled ticks ends a transaction whose clock line is held low too long. An abort input and a soft-reset input give software two further ways out.

Top module: `i2c_burst_master`

## Requirements
- R1: `arb_grant` rises one cycle after `arb_req` is seen while `other_owner` is low. It never rises while `other_owner` is high, and it falls one cycle after `arb_release`.
- R2: A `go` pulse is ignored unless `arb_grant` and `cfg_en` are both high. An ignored pulse leaves `busy` low and drives no line.
- R3: An accepted `go` sets `busy` in the next cycle and clears DONE, NACK and HALT. When `busy` falls, exactly one outcome holds: `done` alone on success, or `nack` or `halt` with `done` low.
- R4: A write sends the address byte first and then `cfg_count` payload bytes in load order, each MSB first, between a START and a STOP. The address byte is the 7-bit target address in bits 7:1 with bit 0 = 0.
- R5: A read sends the address byte with bit 0 = 1 and then receives `cfg_count` bytes. It ACKs every byte except the last, which it NACKs before the STOP. The received bytes are then presented on `rd_byte` in arrival order, and each `rd_en` pulse advances to the next.
- R6: With `cfg_count` = 0, only the address byte is sent. An acknowledged probe ends with `done`.
- R7: A NACK on any transmitted byte, the address byte included, sets `nack`. The engine sends no further bytes and ends with a STOP.
- R8: While the engine releases SCL and waits for it to go high, it counts prescaled ticks. When the count reaches `cfg_tlimit`, it sets `halt`, releases both lines and drops `busy`.
- R9: An `abort` while busy drops `busy`, sets `halt` and releases both lines in the next cycle.
- R10: The engine drives only the SCL/SDA pair chosen by `cfg_pinsel` (0, 1 or 2). At most one SCL and one SDA pull-down are active at a time.
- R11: `clr_done`, `clr_nack` and `clr_halt` each clear their own status bit. `soft_rst` returns the engine to idle, clears all status and both buffer pointers, and releases the lines.
- R12: With STOP generation disabled, the transaction ends with SCL held low and SDA released. The next transaction begins with a repeated START.
- R13: The buffer holds sixteen bytes (the address byte plus fifteen). Loads beyond sixteen are dropped, and `rd_byte` stays on the last entry once the read pointer reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arb_req | input | 1 | Ownership request |
| arb_release | input | 1 | Ownership release |
| other_owner | input | 1 | Another agent holds the bus |
| arb_grant | output | 1 | Ownership granted |
| wr_en | input | 1 | Push `wr_byte` into the buffer (idle only) |
| wr_byte | input | 8 | Byte to load |
| rd_en | input | 1 | Advance the read pointer (idle only) |
| rd_byte | output | 8 | Buffer byte at the read pointer |
| cfg_en | input | 1 | Engine enable |
| cfg_start_en | input | 1 | Generate START |
| cfg_stop_en | input | 1 | Generate STOP |
| cfg_rx | input | 1 | Receive direction for the payload |
| cfg_count | input | 4 | Payload byte count, 0 to 15 |
| cfg_prescale | input | 8 | Clock cycles per tick minus one |
| cfg_tlimit | input | 8 | Time limit in ticks |
| cfg_pinsel | input | 2 | Pin pair select |
| go | input | 1 | Launch pulse |
| abort | input | 1 | End the running transaction |
| soft_rst | input | 1 | Return to idle and clear state |
| clr_done | input | 1 | Clear DONE |
| clr_nack | input | 1 | Clear NACK |
| clr_halt | input | 1 | Clear HALT |
| busy | output | 1 | GO bit; high while a transaction runs |
| done | output | 1 | Transaction completed |
| nack | output | 1 | Target did not acknowledge |
| halt | output | 1 | Time limit expired or aborted |
| scl_low | output | 3 | Pull SCL low, one per pair |
| sda_low | output | 3 | Pull SDA low, one per pair |
| scl_in | input | 3 | Sensed SCL level, one per pair |
| sda_in | input | 3 | Sensed SDA level, one per pair |

## Verification
The bound checker watches, every cycle, the properties that are local in time. These are the grant condition, the rejection of a GO that lacks ownership or enable, the single outcome reported when busy falls, the effect of abort and soft reset one cycle later, and the one-pair drive limit. The ordering of bytes on the wire, ACK placement on reads, where a NACK ends the burst, the time-limit window, the held SCL after a STOP-less transfer and the buffer limits all span many cycles. These are shown only by the bench scenarios, which run against a behavioural target that records what it received and serves what it is asked to send.

// File: rtl/i2c_burst_master.sv
module i2c_burst_master #(
  parameter int MAXB  = 15,
  parameter int PW    = 8,
  parameter int TW    = 8,
  parameter int NPAIR = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arb_req,
  input  logic             arb_release,
  input  logic             other_owner,
  output logic             arb_grant,
  input  logic             wr_en,
  input  logic [7:0]       wr_byte,
  input  logic             rd_en,
  output logic [7:0]       rd_byte,
  input  logic             cfg_en,
  input  logic             cfg_start_en,
  input  logic             cfg_stop_en,
  input  logic             cfg_rx,
  input  logic [$clog2(MAXB+1)-1:0] cfg_count,
  input  logic [PW-1:0]    cfg_prescale,
  input  logic [TW-1:0]    cfg_tlimit,
  input  logic [((NPAIR>1)?$clog2(NPAIR):1)-1:0] cfg_pinsel,
  input  logic             go,
  input  logic             abort,
  input  logic             soft_rst,
  input  logic             clr_done,
  input  logic             clr_nack,
  input  logic             clr_halt,
  output logic             busy,
  output logic             done,
  output logic             nack,
  output logic             halt,
  output logic [NPAIR-1:0] scl_low,
  output logic [NPAIR-1:0] sda_low,
  input  logic [NPAIR-1:0] scl_in,
  input  logic [NPAIR-1:0] sda_in
);
  localparam int DEPTH = MAXB + 1;
  localparam int BW    = $clog2(DEPTH);
  localparam int SW    = (NPAIR > 1) ? $clog2(NPAIR) : 1;

  typedef enum logic [2:0] {S_IDLE, S_STA, S_BYT, S_ACK, S_STO} st_t;

  st_t           st;
  logic [1:0]    q;
  logic [PW-1:0] pcnt, pre;
  logic [TW-1:0] tcnt, tl;
  logic [2:0]    bitn;
  logic [BW-1:0] bidx, nb;
  logic [7:0]    sh;
  logic          scl_l, sda_l, rx, stp, nk;
  logic [SW-1:0] sel;
  logic [BW:0]   wptr, rptr;
  logic [7:0]    mem [DEPTH];
  logic          scl_i, sda_i;

  wire launch  = go && !busy && arb_grant && cfg_en && !soft_rst;
  wire tick    = busy && (pcnt == pre);
  wire wait_hi = (st != S_IDLE) && (q == 2'd2) && !scl_i;
  wire txb     = (bidx == '0) || !rx;
  wire last    = (bidx == nb);
  wire ld_ok   = wr_en && !busy && (wptr < (BW+1)'(DEPTH));
  wire rx_st   = tick && !wait_hi && !soft_rst && !abort && (st == S_ACK) && (q == 2'd3) && !txb;

  always_comb begin
    scl_i = 1'b1;
    sda_i = 1'b1;
    for (int i = 0; i < NPAIR; i++)
      if (sel == SW'(i)) begin
        scl_i = scl_in[i];
        sda_i = sda_in[i];
      end
  end

  for (genvar g = 0; g < NPAIR; g++) begin : g_pins
    assign scl_low[g] = scl_l && (sel == SW'(g));
    assign sda_low[g] = sda_l && (sel == SW'(g));
  end

  assign rd_byte = mem[rptr[BW-1:0]];

  always_ff @(posedge clk) begin
    if (ld_ok) mem[wptr[BW-1:0]] <= wr_byte;
    else if (rx_st) mem[bidx - BW'(1)] <= sh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; q <= '0; pcnt <= '0; pre <= '0; tcnt <= '0; tl <= '0;
      bitn <= '0; bidx <= '0; nb <= '0; sh <= '0; scl_l <= 1'b0; sda_l <= 1'b0;
      rx <= 1'b0; stp <= 1'b0; nk <= 1'b0; sel <= '0; wptr <= '0; rptr <= '0;
      arb_grant <= 1'b0; busy <= 1'b0; done <= 1'b0; nack <= 1'b0; halt <= 1'b0;
    end else begin
      if (arb_release) arb_grant <= 1'b0;
      else if (arb_req && !other_owner) arb_grant <= 1'b1;
      if (clr_done) done <= 1'b0;
      if (clr_nack) nack <= 1'b0;
      if (clr_halt) halt <= 1'b0;
      if (ld_ok) wptr <= wptr + 1'b1;
      if (rd_en && !busy && (rptr < (BW+1)'(DEPTH - 1))) rptr <= rptr + 1'b1;

      if (soft_rst) begin
        st <= S_IDLE; busy <= 1'b0; scl_l <= 1'b0; sda_l <= 1'b0;
        done <= 1'b0; nack <= 1'b0; halt <= 1'b0; wptr <= '0; rptr <= '0;
      end else if (launch) begin
        busy <= 1'b1; done <= 1'b0; nack <= 1'b0; halt <= 1'b0;
        sel <= cfg_pinsel; rx <= cfg_rx; stp <= cfg_stop_en; nb <= cfg_count;
        pre <= cfg_prescale; tl <= cfg_tlimit; pcnt <= '0; q <= '0; tcnt <= '0;
        nk <= 1'b0; wptr <= '0; rptr <= '0; bidx <= '0; bitn <= 3'd7; sh <= mem[0];
        st <= cfg_start_en ? S_STA : S_BYT;
      end else if (busy && abort) begin
        busy <= 1'b0; halt <= 1'b0 | 1'b1; scl_l <= 1'b0; sda_l <= 1'b0; st <= S_IDLE;
      end else if (busy) begin
        pcnt <= tick ? '0 : pcnt + 1'b1;
        if (tick && wait_hi) begin
          if ((tcnt + TW'(1)) >= tl) begin
            halt <= 1'b1; busy <= 1'b0; scl_l <= 1'b0; sda_l <= 1'b0; st <= S_IDLE;
          end else tcnt <= tcnt + TW'(1);
        end else if (tick) begin
          q <= q + 2'd1;
          tcnt <= '0;
          if (q == 2'd1) scl_l <= 1'b0;
          case (st)
            S_STA: begin
              if (q == 2'd0) sda_l <= 1'b0;
              if (q == 2'd2) sda_l <= 1'b1;
              if (q == 2'd3) begin scl_l <= 1'b1; st <= S_BYT; end
            end
            S_BYT: begin
              if (q == 2'd0) sda_l <= txb ? !sh[7] : 1'b0;
              if (q == 2'd2 && !txb) sh <= {sh[6:0], sda_i};
              if (q == 2'd3) begin
                scl_l <= 1'b1;
                if (bitn == 3'd0) st <= S_ACK;
                else begin
                  bitn <= bitn - 3'd1;
                  if (txb) sh <= {sh[6:0], 1'b0};
                end
              end
            end
            S_ACK: begin
              if (q == 2'd0) sda_l <= !txb && !last;
              if (q == 2'd2 && txb && sda_i) nk <= 1'b1;
              if (q == 2'd3) begin
                scl_l <= 1'b1;
                if ((txb && nk) || last) begin
                  if (txb && nk) nack <= 1'b1;
                  if (stp) st <= S_STO;
                  else begin
                    busy <= 1'b0; done <= !(txb && nk); sda_l <= 1'b0; st <= S_IDLE;
                  end
                end else begin
                  bidx <= bidx + BW'(1);
                  bitn <= 3'd7;
                  sh <= rx ? 8'h00 : mem[bidx + BW'(1)];
                  st <= S_BYT;
                end
              end
            end
            S_STO: begin
              if (q == 2'd0) sda_l <= 1'b1;
              if (q == 2'd3) begin
                sda_l <= 1'b0; busy <= 1'b0; done <= !nk; st <= S_IDLE;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_burst_master_chk.sv
module i2c_burst_master_chk #(
  parameter int NPAIR = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arb_req,
  input logic             other_owner,
  input logic             arb_grant,
  input logic             go,
  input logic             cfg_en,
  input logic             abort,
  input logic             soft_rst,
  input logic             busy,
  input logic             done,
  input logic             nack,
  input logic             halt,
  input logic [NPAIR-1:0] scl_low,
  input logic [NPAIR-1:0] sda_low
);
  // R1
  grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_grant) |-> ($past(arb_req) && !$past(other_owner)));

  // R2
  go_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy && !(arb_grant && cfg_en)) |=> !busy);

  // R3
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(soft_rst)) |-> (done ^ (nack | halt)));

  // R9
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && abort && !soft_rst) |=> (!busy && halt && scl_low == '0 && sda_low == '0));

  // R10
  one_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(scl_low) && $onehot0(sda_low));

  // R11
  srst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!busy && !done && !nack && !halt && scl_low == '0));
endmodule

bind i2c_burst_master i2c_burst_master_chk #(.NPAIR(NPAIR)) u_chk (
  .clk(clk), .rst_n(rst_n), .arb_req(arb_req), .other_owner(other_owner),
  .arb_grant(arb_grant), .go(go), .cfg_en(cfg_en), .abort(abort),
  .soft_rst(soft_rst), .busy(busy), .done(done), .nack(nack), .halt(halt),
  .scl_low(scl_low), .sda_low(sda_low)
);

// File: tb/tb_i2c_burst_master.sv
`timescale 1ns/1ps
module tb_i2c_burst_master;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic arb_req = 0, arb_release = 0, other_owner = 0, arb_grant;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wr_byte = 0, rd_byte;
  logic cfg_en = 1, cfg_start_en = 1, cfg_stop_en = 1, cfg_rx = 0;
  logic [3:0] cfg_count = 0;
  logic [7:0] cfg_prescale = 1, cfg_tlimit = 48;
  logic [1:0] cfg_pinsel = 0;
  logic go = 0, abort = 0, soft_rst = 0, clr_done = 0, clr_nack = 0, clr_halt = 0;
  logic busy, done, nack, halt;
  logic [2:0] scl_low, sda_low, scl_in, sda_in;

  i2c_burst_master dut (
    .clk(clk), .rst_n(rst_n), .arb_req(arb_req), .arb_release(arb_release),
    .other_owner(other_owner), .arb_grant(arb_grant), .wr_en(wr_en), .wr_byte(wr_byte),
    .rd_en(rd_en), .rd_byte(rd_byte), .cfg_en(cfg_en), .cfg_start_en(cfg_start_en),
    .cfg_stop_en(cfg_stop_en), .cfg_rx(cfg_rx), .cfg_count(cfg_count),
    .cfg_prescale(cfg_prescale), .cfg_tlimit(cfg_tlimit), .cfg_pinsel(cfg_pinsel),
    .go(go), .abort(abort), .soft_rst(soft_rst), .clr_done(clr_done),
    .clr_nack(clr_nack), .clr_halt(clr_halt), .busy(busy), .done(done), .nack(nack),
    .halt(halt), .scl_low(scl_low), .sda_low(sda_low), .scl_in(scl_in), .sda_in(sda_in)
  );

  // Bus model: one target on the selected pair
  localparam logic [6:0] TGT = 7'h3A;
  int   bsel = 0;
  logic stretch = 0, s_low = 0;
  logic scl_b, sda_b;
  always_comb begin
    for (int i = 0; i < 3; i++) begin
      scl_in[i] = !scl_low[i] && !(i == bsel && stretch);
      sda_in[i] = !sda_low[i] && !(i == bsel && s_low);
    end
    scl_b = scl_in[bsel];
    sda_b = sda_in[bsel];
  end

  logic [7:0] wmem [16];
  logic [7:0] rmem [16];
  logic [7:0] seen_addr;
  int slv_len = 0, nack_at = -1, wcount = 0, mnack = -1;

  initial begin
    logic [7:0] b;
    logic a;
    forever begin
      do @(negedge sda_b); while (!scl_b);
      for (int i = 7; i >= 0; i--) begin @(posedge scl_b); b[i] = sda_b; end
      seen_addr = b;
      @(negedge scl_b); #1;
      if (b[7:1] == TGT) begin
        s_low = 1; @(negedge scl_b); #1; s_low = 0;
        if (!b[0]) begin
          for (int k = 0; k < slv_len; k++) begin
            for (int i = 7; i >= 0; i--) begin @(posedge scl_b); b[i] = sda_b; end
            wmem[k] = b; wcount++;
            @(negedge scl_b); #1;
            if (k == nack_at) break;
            s_low = 1; @(negedge scl_b); #1; s_low = 0;
          end
        end else begin
          for (int k = 0; k < slv_len; k++) begin
            for (int i = 7; i >= 0; i--) begin s_low = !rmem[k][i]; @(negedge scl_b); #1; end
            s_low = 0;
            @(posedge scl_b); a = sda_b;
            @(negedge scl_b); #1;
            if (a) begin mnack = k; break; end
          end
        end
      end
    end
  end

  // Counts any pull-down on a pair other than the selected one
  int foreign = 0;
  always @(posedge clk)
    for (int i = 0; i < 3; i++)
      if ((scl_low[i] || sda_low[i]) && i != bsel) foreign++;

  int errors = 0, checks = 0;
  logic [7:0] tdata [16];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic r);
    return {a, r};
  endfunction

  function automatic logic [2:0] exp_status(input bit ok, input bit nk);
    return ok ? 3'b100 : (nk ? 3'b010 : 3'b001);
  endfunction

  task automatic pulse_go();
    go = 1; @(negedge clk); go = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 40000) begin @(negedge clk); n++; end
  endtask

  task automatic load(input logic [6:0] a, input logic r, input int cnt);
    wr_en = 1; wr_byte = addr_byte(a, r); @(negedge clk);
    if (!r) for (int k = 0; k < cnt; k++) begin wr_byte = tdata[k]; @(negedge clk); end
    wr_en = 0;
  endtask

  task automatic run_txn(input logic [6:0] a, input logic r, input int cnt,
                         input int ps, input int sel, input logic stp);
    bsel = sel; slv_len = cnt; wcount = 0; mnack = -1;
    load(a, r, cnt);
    cfg_rx = r; cfg_count = 4'(cnt); cfg_prescale = 8'(ps);
    cfg_pinsel = 2'(sel); cfg_stop_en = stp;
    pulse_go();
    wait_idle();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int f0;
    int unsigned sd;
    sd = $urandom(32'd4242);
    for (int k = 0; k < 16; k++) rmem[k] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3 reset state
    chk("R3 reset status", {busy, done, nack, halt}, 4'b0000);
    chk("R10 reset lines", {scl_low, sda_low}, 6'b0);
    chk("R1 reset grant", arb_grant, 0);

    // R1 ownership
    other_owner = 1; arb_req = 1; repeat (3) @(negedge clk);
    chk("R1 no grant while other owner", arb_grant, 0);
    other_owner = 0; @(negedge clk);
    chk("R1 grant after request", arb_grant, 1);
    arb_req = 0; arb_release = 1; @(negedge clk); arb_release = 0;
    chk("R1 release", arb_grant, 0);

    // R2 go without grant
    pulse_go();
    chk("R2 go ignored without grant", {busy, scl_low, sda_low}, 0);
    arb_req = 1; @(negedge clk); arb_req = 0;
    cfg_en = 0; pulse_go();
    chk("R2 go ignored with engine disabled", {busy, scl_low, sda_low}, 0);
    cfg_en = 1;

    // R3/R4 first write with busy observation
    for (int k = 0; k < 16; k++) tdata[k] = 8'($urandom);
    bsel = 1; slv_len = 3; wcount = 0;
    load(TGT, 0, 3);
    cfg_rx = 0; cfg_count = 3; cfg_prescale = 1; cfg_pinsel = 1; cfg_stop_en = 1;
    pulse_go();
    chk("R3 busy after go", busy, 1);
    wait_idle(); @(negedge clk);
    chk("R3 success status", {done, nack, halt}, exp_status(1, 0));
    chk("R4 address byte", seen_addr, addr_byte(TGT, 0));
    chk("R4 byte count", wcount, 3);

    // Random transactions: R4, R5, R6, R10
    for (int t = 0; t < 14; t++) begin
      logic r;
      int cnt, sel, ps;
      r   = 1'($urandom);
      cnt = (t == 0) ? 15 : (t == 1) ? 0 : int'($urandom % 16);
      sel = int'($urandom % 3);
      ps  = int'($urandom % 3);
      for (int k = 0; k < 16; k++) begin tdata[k] = 8'($urandom); rmem[k] = 8'($urandom); end
      f0 = foreign;
      run_txn(TGT, r, cnt, ps, sel, 1);
      chk(cnt == 0 ? "R6 probe status" : "R3 status", {done, nack, halt}, exp_status(1, 0));
      chk("R10 unselected pairs idle", foreign - f0, 0);
      chk(r ? "R5 address byte" : "R4 address byte", seen_addr, addr_byte(TGT, r));
      if (!r) begin
        chk("R4 write count", wcount, cnt);
        for (int k = 0; k < cnt; k++) chk("R4 write data", wmem[k], tdata[k]);
      end else begin
        chk("R5 master NACK on last byte", mnack, cnt - 1);
        for (int k = 0; k < cnt; k++) begin
          chk("R5 read data order", rd_byte, rmem[k]);
          rd_en = 1; @(negedge clk); rd_en = 0;
        end
      end
    end

    // R7 NACK mid burst
    for (int k = 0; k < 16; k++) tdata[k] = 8'(k + 8'h20);
    nack_at = 2;
    run_txn(TGT, 0, 6, 1, 0, 1);
    nack_at = -1;
    chk("R7 nack status", {done, nack, halt}, exp_status(0, 1));
    chk("R7 no bytes after nack", wcount, 3);
    chk("R7 stop released lines", {scl_low, sda_low}, 0);
    // R11 W1C
    clr_nack = 1; @(negedge clk); clr_nack = 0;
    chk("R11 clear nack", nack, 0);
    // R7 address not acknowledged
    run_txn(7'h11, 0, 2, 1, 2, 1);
    chk("R7 address nack", {done, nack, halt}, exp_status(0, 1));

    // R8 time limit while SCL held low
    stretch = 1;
    load(TGT, 0, 0);
    cfg_count = 0; cfg_prescale = 1; cfg_tlimit = 20; cfg_pinsel = 0; bsel = 0;
    pulse_go();
    repeat (20 * 2 - 2) @(negedge clk);
    chk("R8 still waiting before limit", busy, 1);
    repeat (3 * 2 + 4) @(negedge clk);
    chk("R8 halt after limit", {busy, done, nack, halt}, 4'b0001);
    chk("R8 lines released", {scl_low, sda_low}, 0);
    stretch = 0; cfg_tlimit = 48;
    clr_halt = 1; @(negedge clk); clr_halt = 0;
    chk("R11 clear halt", halt, 0);

    // R12 probe without STOP, then repeated START
    run_txn(TGT, 0, 0, 1, 1, 0);
    chk("R12 done without stop", done, 1);
    chk("R12 SCL held low", scl_low, 3'b010);
    chk("R12 SDA released", sda_low, 0);
    for (int k = 0; k < 16; k++) tdata[k] = 8'(8'hA0 + k);
    run_txn(TGT, 0, 2, 1, 1, 1);
    chk("R12 repeated start transfer", {done, wcount}, {1'b1, 32'd2});
    clr_done = 1; @(negedge clk); clr_done = 0;
    chk("R11 clear done", done, 0);

    // R11 soft reset clears status
    run_txn(TGT, 0, 0, 0, 0, 1);
    soft_rst = 1; @(negedge clk); soft_rst = 0;
    chk("R11 soft reset status", {busy, done, nack, halt}, 0);

    // R13 buffer limit
    wr_en = 1;
    for (int k = 0; k < 17; k++) begin wr_byte = 8'(k + 1); @(negedge clk); end
    wr_en = 0;
    for (int k = 0; k < 16; k++) begin
      chk("R13 buffered byte", rd_byte, 8'(k + 1));
      rd_en = 1; @(negedge clk); rd_en = 0;
    end
    chk("R13 pointer holds on last entry", rd_byte, 8'd16);

    // R9 abort in progress
    run_txn(TGT, 0, 0, 0, 0, 1);
    bsel = 0; slv_len = 10;
    load(TGT, 0, 10);
    cfg_count = 10; cfg_prescale = 1; cfg_rx = 0; cfg_pinsel = 0;
    pulse_go();
    repeat (150) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    chk("R9 abort status", {busy, done, halt}, 3'b001);
    chk("R9 abort released lines", {scl_low, sda_low}, 0);

    finish_run();
  end
endmodule